// File: doc/BRIEF.md
# Output Clock Divider Factor Calculator

This block works out the settings for a two-stage clock output divider: a power-of-two prescaler selected by an exponent `p` (0 to 3) followed by a linear divider programmed through a 5-bit field `m` that divides by `m + 1`. The caller presents a parent frequency and a desired output frequency as unsigned integers. The block returns `p`, `m`, and the output frequency that those settings actually give. Because the hardware can only divide, the result is often not the requested frequency.

The calculation runs one shared iterative divider twice. The first pass finds the integer ratio of parent to request. The second pass finds the achieved rate. A request is accepted on a valid/ready handshake. The result is offered on a second valid/ready handshake.

Back-pressure works as follows. The block takes only one request at a time. `in_ready` is high only while the block is idle. From acceptance until the result is taken, `in_ready` stays low, and any `in_valid` during that time is ignored. Once `out_valid` rises, it stays high and all result fields stay constant until a cycle in which `out_ready` is also high. The block returns to idle on the clock edge after that handshake.

Top module: `clkout_factor_calc`

## Requirements
- R1: A requested frequency above the parent frequency is replaced by the parent frequency. For a nonzero parent, the result is then p = 0, m = 0, and an achieved rate equal to the parent.
- R2: The ratio used for all later steps is the parent frequency divided by the (possibly clamped) request, with any fraction discarded.
- R3: p is the smallest value in 0..3 for which ratio / 2^p is below 32. If no such value exists, p is 3. So p = 0 for ratios below 32, p = 1 below 64, p = 2 below 128, and p = 3 otherwise.
- R4: The linear divide is ratio / 2^p rounded up to the next integer. The m output equals that linear divide minus one.
- R5: The achieved rate output equals (parent >> p) divided by the linear divide, with any fraction discarded.
- R6: A requested frequency of zero, including one that results from clamping to a zero parent, acts as the largest possible ratio. It gives p = 3 and m = 31.
- R7: If the rounded linear divide would exceed 32, it is held at 32. This gives m = 31, and the achieved rate uses 32 as the divisor.
- R8: `in_ready` drops on the edge that accepts a request and stays low until the result has been taken. An `in_valid` pulse during that time changes neither the result nor the state.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_p`, `out_m` and `out_rate` stay unchanged.
- R10: `out_valid` rises exactly 2*FREQ_W + 2 clock edges after the accepting edge (66 edges for the default 32-bit width).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to accept a request |
| in_parent | input | FREQ_W | Parent frequency |
| in_request | input | FREQ_W | Desired output frequency |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_p | output | P_W | Prescale exponent (divide by 2^p) |
| out_m | output | M_WIDTH | Linear divide minus one |
| out_rate | output | FREQ_W | Achieved output frequency |

## Verification
All three result fields become valid together, on the 2*FREQ_W + 2nd edge after the edge on which `in_valid` and `in_ready` were both high. The first divide needs FREQ_W + 1 edges, one edge then starts the second divide, and the second divide plus the capture into the output register needs FREQ_W + 1 more.

The bench counts edges from the accepting edge and samples on the falling edge after each one. It requires `out_valid` to be low at every sample before edge 66 and high at edge 66. Only then does it compare the fields with its own model.

While `out_valid` is high, the bench holds `out_ready` low for several cycles and resamples each cycle, confirming that the fields do not move. During the busy period it pulses `in_valid` once to show that the pulse is refused and has no effect on the result.

// File: rtl/clkout_factor_pkg.sv
package clkout_factor_pkg;

  // Sequencer states of the calculator.
  typedef enum logic [1:0] {
    ST_IDLE,   // waiting for a request
    ST_RATIO,  // first divide: parent / request
    ST_RATE,   // second divide: (parent >> p) / linear divide
    ST_OFFER   // result presented, waiting for consumer
  } calc_state_e;

  // Clock edges from the accepting edge to out_valid rising.
  function automatic int unsigned result_latency(input int unsigned width);
    return 2 * width + 2;
  endfunction

endpackage

// File: rtl/cfc_serial_div.sv
// Restoring divider, one quotient bit per clock edge.
// The start edge loads the operands. The next W edges each produce one bit.
// done is a one-cycle pulse after the last of those edges.
// A zero denominator yields an all-ones quotient.
module cfc_serial_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  den_q;
  logic [W-1:0]  work_q;  // dividend bits shift out at the top, quotient bits shift in at the bottom
  logic [CW-1:0] left_q;

  logic [W:0] trial;
  logic [W:0] diff;

  always_comb begin
    trial = {rem_q, work_q[W-1]};
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      work_q <= '0;
      left_q <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q  <= '0;
        den_q  <= den;
        work_q <= num;
        left_q <= CW'(W);
        busy   <= 1'b1;
      end else if (busy) begin
        if (!diff[W]) begin
          rem_q  <= diff[W-1:0];
          work_q <= {work_q[W-2:0], 1'b1};
        end else begin
          rem_q  <= trial[W-1:0];
          work_q <= {work_q[W-2:0], 1'b0};
        end
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = work_q;

endmodule

// File: rtl/cfc_factor_pick.sv
// From the integer ratio, selects the prescale exponent and the rounded-up,
// saturated linear divide. Purely combinational.
module cfc_factor_pick #(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned M_WIDTH = 5,
  parameter int unsigned P_MAX   = 3,
  localparam int unsigned P_W    = $clog2(P_MAX + 1)
) (
  input  logic [FREQ_W-1:0]  ratio,
  output logic [P_W-1:0]     p,
  output logic [M_WIDTH-1:0] m,
  output logic [FREQ_W-1:0]  lin
);
  localparam logic [FREQ_W:0] LIMIT = (FREQ_W + 1)'(1) << M_WIDTH;

  logic [FREQ_W:0] ceil_a [P_MAX+1];
  logic            fits_a [P_MAX+1];

  // One candidate per prescale setting.
  for (genvar i = 0; i <= P_MAX; i++) begin : g_cand
    localparam logic [FREQ_W-1:0] LOW_MASK = FREQ_W'((64'd1 << i) - 64'd1);
    logic [FREQ_W-1:0] shifted;
    assign shifted   = ratio >> i;
    assign fits_a[i] = {1'b0, shifted} < LIMIT;
    assign ceil_a[i] = {1'b0, shifted} + {{FREQ_W{1'b0}}, |(ratio & LOW_MASK)};
  end

  logic [FREQ_W:0] rounded;

  always_comb begin
    p = P_W'(P_MAX);
    for (int i = P_MAX; i >= 0; i--) begin
      if (fits_a[i]) p = P_W'(i);
    end
    rounded = ceil_a[p];
    if (rounded > LIMIT) rounded = LIMIT;
    if (rounded == '0) rounded = (FREQ_W + 1)'(1);
    lin = rounded[FREQ_W-1:0];
    m   = M_WIDTH'(rounded - (FREQ_W + 1)'(1));
  end

endmodule

// File: rtl/clkout_factor_calc.sv
module clkout_factor_calc
  import clkout_factor_pkg::*;
#(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned M_WIDTH = 5,
  parameter int unsigned P_MAX   = 3,
  localparam int unsigned P_W    = $clog2(P_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FREQ_W-1:0]  in_parent,
  input  logic [FREQ_W-1:0]  in_request,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [P_W-1:0]     out_p,
  output logic [M_WIDTH-1:0] out_m,
  output logic [FREQ_W-1:0]  out_rate
);
  calc_state_e state_q;

  logic [FREQ_W-1:0]  parent_q;
  logic [FREQ_W-1:0]  req_clamped;
  logic               accept;
  logic               div_start;
  logic               div_busy;
  logic               div_done;
  logic [FREQ_W-1:0]  div_num;
  logic [FREQ_W-1:0]  div_den;
  logic [FREQ_W-1:0]  div_quot;
  logic [P_W-1:0]     pick_p;
  logic [M_WIDTH-1:0] pick_m;
  logic [FREQ_W-1:0]  pick_lin;

  assign in_ready    = (state_q == ST_IDLE);
  assign accept      = in_valid && in_ready;
  assign req_clamped = (in_request > in_parent) ? in_parent : in_request;

  // The divider is shared between the two passes.
  always_comb begin
    div_start = 1'b0;
    div_num   = in_parent;
    div_den   = req_clamped;
    if (state_q == ST_IDLE) begin
      div_start = accept;
    end else if (state_q == ST_RATIO) begin
      div_start = div_done;
      div_num   = parent_q >> pick_p;
      div_den   = pick_lin;
    end
  end

  cfc_serial_div #(.W(FREQ_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_quot)
  );

  cfc_factor_pick #(
    .FREQ_W  (FREQ_W),
    .M_WIDTH (M_WIDTH),
    .P_MAX   (P_MAX)
  ) u_pick (
    .ratio (div_quot),
    .p     (pick_p),
    .m     (pick_m),
    .lin   (pick_lin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      parent_q  <= '0;
      out_valid <= 1'b0;
      out_p     <= '0;
      out_m     <= '0;
      out_rate  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            parent_q <= in_parent;
            state_q  <= ST_RATIO;
          end
        end
        ST_RATIO: begin
          if (div_done) begin
            out_p   <= pick_p;
            out_m   <= pick_m;
            state_q <= ST_RATE;
          end
        end
        ST_RATE: begin
          if (div_done && !div_busy) begin
            out_rate  <= div_quot;
            out_valid <= 1'b1;
            state_q   <= ST_OFFER;
          end
        end
        default: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/clkout_factor_calc_chk.sv
module clkout_factor_calc_chk #(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned M_WIDTH = 5,
  parameter int unsigned P_MAX   = 3,
  localparam int unsigned P_W    = $clog2(P_MAX + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [FREQ_W-1:0]  in_parent,
  input logic [FREQ_W-1:0]  in_request,
  input logic               out_valid,
  input logic               out_ready,
  input logic [P_W-1:0]     out_p,
  input logic [M_WIDTH-1:0] out_m,
  input logic [FREQ_W-1:0]  out_rate
);
  localparam int unsigned LAT = 2 * FREQ_W + 2;
  localparam int unsigned LW  = $clog2(LAT + 2) + 1;
  localparam logic [M_WIDTH-1:0] HALF_M = M_WIDTH'((1 << (M_WIDTH - 1)) - 1);

  logic              acc;
  logic [LW-1:0]     lat_cnt;
  logic              zero_pend;
  logic              clamp_pend;
  logic [FREQ_W-1:0] par_seen;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt    <= '1;
      zero_pend  <= 1'b0;
      clamp_pend <= 1'b0;
      par_seen   <= '0;
    end else begin
      if (acc) begin
        lat_cnt    <= '0;
        zero_pend  <= (in_request == '0) || (in_parent == '0);
        clamp_pend <= (in_request > in_parent) && (in_parent != '0);
        par_seen   <= in_parent;
      end else if (!out_valid && lat_cnt != '1) begin
        lat_cnt <= lat_cnt + 1'b1;
      end
    end
  end

  // R8: accepting a request closes the input until the result is taken
  a_r8_busy_closed: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !in_ready);
  // R8: never open for input while a result is on offer
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R9: the offer and its fields hold under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_p) && $stable(out_m) && $stable(out_rate));
  // R10: fixed latency from accept to offer
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_cnt == LW'(LAT));
  // R3: any nonzero prescale means the ratio reached 32, so the linear divide is at least 16
  a_r3_prescale_floor: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_p != '0 |-> out_m >= HALF_M);
  // R6: zero request gives the largest settings
  a_r6_zero_request: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && zero_pend |-> out_p == P_W'(P_MAX) && out_m == '1);
  // R1: an over-range request passes the parent straight through
  a_r1_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && clamp_pend |-> out_p == '0 && out_m == '0 && out_rate == par_seen);

endmodule

bind clkout_factor_calc clkout_factor_calc_chk #(
  .FREQ_W  (FREQ_W),
  .M_WIDTH (M_WIDTH),
  .P_MAX   (P_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_parent  (in_parent),
  .in_request (in_request),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_p      (out_p),
  .out_m      (out_m),
  .out_rate   (out_rate)
);

// File: tb/tb_clkout_factor_calc.sv
`timescale 1ns/1ps
module tb_clkout_factor_calc;
  localparam int LAT = 66;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_parent = '0;
  logic [31:0] in_request = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [1:0]  out_p;
  logic [4:0]  out_m;
  logic [31:0] out_rate;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  clkout_factor_calc dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_parent  (in_parent),
    .in_request (in_request),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_p      (out_p),
    .out_m      (out_m),
    .out_rate   (out_rate)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_checks = n_checks + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference computed from the requirements.
  function automatic void model(input logic [31:0] par, input logic [31:0] req,
                                output logic [1:0] ep, output logic [4:0] em,
                                output logic [31:0] er);
    longint unsigned rc, dv, ln;
    int pp;
    rc = (req > par) ? par : req;
    dv = (rc == 0) ? 64'hFFFF_FFFF : par / rc;
    if (dv < 32) pp = 0;
    else if (dv / 2 < 32) pp = 1;
    else if (dv / 4 < 32) pp = 2;
    else pp = 3;
    ln = (dv + (64'd1 << pp) - 1) >> pp;
    if (ln > 32) ln = 32;
    ep = 2'(pp);
    em = 5'(ln - 1);
    er = 32'((longint'(par) >> pp) / ln);
  endfunction

  task automatic run_one(input string tag, input logic [31:0] par, input logic [31:0] req,
                         input int hold);
    logic [1:0]  ep;
    logic [4:0]  em;
    logic [31:0] er;
    int          rise_at;
    logic        busy_ok;
    logic        stable_ok;
    model(par, req, ep, em, er);
    @(negedge clk);
    chk({tag, " R8 idle ready"}, in_ready, 1);
    in_valid   = 1'b1;
    in_parent  = par;
    in_request = req;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rise_at  = -1;
    busy_ok  = 1'b1;
    for (int k = 1; k <= LAT + 8; k++) begin
      if (k == 4) begin
        if (in_ready) busy_ok = 1'b0;
        in_valid   = 1'b1;
        in_parent  = 32'h0BAD_0000 ^ par;
        in_request = 32'd3;
      end
      if (k == 5) in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (out_valid) begin
        rise_at = k;
        break;
      end
    end
    chk({tag, " R8 busy refuses input"}, busy_ok, 1);
    chk({tag, " R10 latency"}, longint'(rise_at), LAT);
    chk({tag, " R3 p"}, out_p, ep);
    chk({tag, " R4 m"}, out_m, em);
    chk({tag, " R5 rate"}, out_rate, er);
    stable_ok = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk);
      @(negedge clk);
      if (!out_valid || out_p != ep || out_m != em || out_rate != er) stable_ok = 1'b0;
    end
    if (hold > 0) chk({tag, " R9 hold under back-pressure"}, stable_ok, 1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk({tag, " R9 offer cleared"}, out_valid, 0);
  endtask

  initial begin
    logic [31:0] par;
    logic [31:0] req;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("reset out_valid", out_valid, 0);
    chk("reset R8 in_ready", in_ready, 1);
    rst_n = 1'b1;

    run_one("R1 over-range", 32'd1000, 32'd5000, 3);
    run_one("R1 equal", 32'd777, 32'd777, 0);
    run_one("R6 zero request", 32'd24000000, 32'd0, 2);
    run_one("R6 zero parent", 32'd0, 32'd9, 0);
    run_one("R2 small ratio", 32'd1000, 32'd37, 0);          // ratio 27, p 0
    run_one("R4 round up p1", 32'd1000, 32'd30, 0);          // ratio 33, p 1, lin 17
    run_one("R3 p2 boundary", 32'd64, 32'd1, 0);             // ratio 64, p 2
    run_one("R3 p1 top", 32'd63, 32'd1, 0);                  // ratio 63, p 1, lin 32
    run_one("R7 saturate", 32'd24000000, 32'd32768, 4);      // ratio 732, m 31
    run_one("R7 max parent", 32'hFFFF_FFFF, 32'd1, 0);

    for (int i = 0; i < 40; i++) begin
      par = $urandom;
      case ($urandom % 4)
        0: req = par / (1 + ($urandom % 300));
        1: req = $urandom;
        2: req = par >> ($urandom % 12);
        default: req = $urandom % 64;
      endcase
      run_one("R5 random", par, req, int'($urandom % 3));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule